// File: doc/BRIEF.md
# Sum-Term Register Macrocell

This block is one configurable logic cell that sits behind a programmable AND/OR array. The array hands it four terms: a data sum term, an enable sum term, an output-enable product term and a reset product term that all cells share. The cell applies a programmable XOR to both sum terms to set their polarity. It then passes the data value straight through, stores it in a register on the common output clock with the enable term acting as a clock enable, or stores it in a register clocked by the enable term itself. Each cell picks one of these behaviours through its own configuration inputs.

The stored or passed value returns to the array as true and complement feedback. For a cell that reaches a pin, the value also goes out through an inverting buffer. The pin has its own output enable, and a second feedback taken from the pin side shows what is actually on the pin. The parameter `BURIED` builds a cell that never drives its pin. Such a cell feeds the array only from its direct path, and its pin-side feedback carries the external level.

The three-state pad is modelled by the pair `pin_drive` / `pin_en`. Holding `pin_en` low stands for high impedance. `pin_ext` is the level an outside driver puts on the pad.

Top module: `sumterm_macrocell`

## Requirements
- R1: With `cfg_mode` equal to 2'b00 or the reserved 2'b11, the cell is combinatorial, and `fb_true` equals `d_term ^ cfg_d_inv` with no clock involved.
- R2: With `cfg_mode` equal to 2'b10, on each rising edge of `clk_out` the cell loads `d_term ^ cfg_d_inv` when `e_term ^ cfg_e_inv` is 1. When that value is 0, the cell keeps its previous value.
- R3: With `cfg_mode` equal to 2'b01, the cell loads `d_term ^ cfg_d_inv` on every rising edge of `e_term ^ cfg_e_inv`, independent of `clk_out`. When `cfg_e_inv` is 1, a falling `e_term` is the edge that loads.
- R4: While `clr_term` is 1 or `rst_n` is 0, both registers are cleared to 0 at once, without waiting for a clock. A cleared register in either register mode shows `fb_true` = 0 and `pin_drive` = 1.
- R5: On a non-buried cell, `pin_drive` is always the inverse of `fb_true`.
- R6: `fb_comp` is always the inverse of `fb_true`.
- R7: On a non-buried cell, `pin_en` follows `oe_term`. When `pin_en` is 1, `fb_pin` equals `pin_drive`. When it is 0, `fb_pin` equals `pin_ext`.
- R8: With `BURIED` = 1, `pin_en` and `pin_drive` stay 0 whatever `oe_term` does, `fb_pin` equals `pin_ext`, and `fb_true`/`fb_comp` behave exactly as in a non-buried cell.
- R9: A register mode ignores the other mode's clock. In mode 2'b10, edges of the enable term between `clk_out` edges leave `fb_true` unchanged. In mode 2'b01, `clk_out` edges without an enable-term edge leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_out | input | 1 | Common output clock for the clock-enable register mode |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously upstream |
| clr_term | input | 1 | Shared active-high asynchronous reset product term |
| cfg_mode | input | 2 | 00/11 combinatorial, 01 sum-term clock, 10 clock-enable register |
| cfg_d_inv | input | 1 | XOR polarity on the data sum term |
| cfg_e_inv | input | 1 | XOR polarity on the enable sum term |
| d_term | input | 1 | Data sum term from the array |
| e_term | input | 1 | Enable / clock sum term from the array |
| oe_term | input | 1 | Output-enable product term for the pin |
| pin_ext | input | 1 | Level seen on the pad when it is not driven |
| pin_drive | output | 1 | Inverted cell value driven to the pad |
| pin_en | output | 1 | Pad driver enable (0 = high impedance) |
| fb_true | output | 1 | Direct feedback, true form |
| fb_comp | output | 1 | Direct feedback, complemented form |
| fb_pin | output | 1 | Feedback through the pad input path |

## Verification
The combinatorial results (R1, R5 to R8) and the asynchronous clear (R4) settle within the same time step as their stimulus, so the bench checks them 1 ns after it drives, well before the next clock edge. The clock-enable register (R2) has one flop on its path, so its value is due just after the first `clk_out` rising edge that follows the stimulus. Inputs change on falling edges and are checked 1 ns after the rising edge. The sum-term-clocked register (R3) updates on the edge of the enable term itself, so the bench makes that edge in the middle of a clock low phase and checks 1 ns later. For R9, the bench lets a whole number of `clk_out` edges pass with no enable edge before checking that the cell held its value.

// File: rtl/sumterm_pkg.sv
package sumterm_pkg;
  typedef enum logic [1:0] {
    MODE_COMB  = 2'b00,
    MODE_STCLK = 2'b01,
    MODE_DE    = 2'b10,
    MODE_RSVD  = 2'b11
  } cell_mode_e;
endpackage

// File: rtl/sumterm_polarity.sv
module sumterm_polarity (
  input  logic d_term,
  input  logic e_term,
  input  logic cfg_d_inv,
  input  logic cfg_e_inv,
  output logic d_pol,
  output logic e_pol
);
  // programmable inversion of both sum terms
  always_comb begin
    d_pol = d_term ^ cfg_d_inv;
    e_pol = e_term ^ cfg_e_inv;
  end
endmodule

// File: rtl/sumterm_store.sv
module sumterm_store
  import sumterm_pkg::*;
(
  input  logic       clk_out,
  input  logic       rst_n,
  input  logic       clr_term,
  input  logic [1:0] cfg_mode,
  input  logic       d_pol,
  input  logic       e_pol,
  output logic       cell_val
);
  cell_mode_e mode;
  logic       arst;
  logic       de_q, de_nxt;
  logic       st_q, st_nxt;

  assign mode = cell_mode_e'(cfg_mode);
  assign arst = ~rst_n | clr_term;

  // clock-enable register on the shared output clock
  always_comb begin
    de_nxt = de_q;
    if (e_pol) de_nxt = d_pol;
  end

  always_ff @(posedge clk_out or posedge arst) begin
    if (arst) de_q <= 1'b0;
    else      de_q <= de_nxt;
  end

  // register clocked by the polarity-corrected enable term
  always_comb st_nxt = d_pol;

  always_ff @(posedge e_pol or posedge arst) begin
    if (arst) st_q <= 1'b0;
    else      st_q <= st_nxt;
  end

  always_comb begin
    unique case (mode)
      MODE_STCLK: cell_val = st_q;
      MODE_DE:    cell_val = de_q;
      default:    cell_val = d_pol;
    endcase
  end
endmodule

// File: rtl/sumterm_pinstage.sv
module sumterm_pinstage #(
  parameter bit BURIED = 1'b0
) (
  input  logic cell_val,
  input  logic oe_term,
  input  logic pin_ext,
  output logic pin_drive,
  output logic pin_en,
  output logic fb_true,
  output logic fb_comp,
  output logic fb_pin
);
  always_comb begin
    fb_true = cell_val;
    fb_comp = ~cell_val;
  end

  generate
    if (BURIED) begin : g_buried
      logic unused_oe;
      assign unused_oe = oe_term;
      assign pin_drive = 1'b0;
      assign pin_en    = 1'b0;
      assign fb_pin    = pin_ext;
    end else begin : g_io
      assign pin_drive = ~cell_val;
      assign pin_en    = oe_term;
      assign fb_pin    = oe_term ? ~cell_val : pin_ext;
    end
  endgenerate
endmodule

// File: rtl/sumterm_macrocell.sv
module sumterm_macrocell #(
  parameter bit BURIED = 1'b0
) (
  input  logic       clk_out,
  input  logic       rst_n,
  input  logic       clr_term,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_d_inv,
  input  logic       cfg_e_inv,
  input  logic       d_term,
  input  logic       e_term,
  input  logic       oe_term,
  input  logic       pin_ext,
  output logic       pin_drive,
  output logic       pin_en,
  output logic       fb_true,
  output logic       fb_comp,
  output logic       fb_pin
);
  logic d_pol, e_pol, cell_val;

  sumterm_polarity u_pol (
    .d_term    (d_term),
    .e_term    (e_term),
    .cfg_d_inv (cfg_d_inv),
    .cfg_e_inv (cfg_e_inv),
    .d_pol     (d_pol),
    .e_pol     (e_pol)
  );

  sumterm_store u_store (
    .clk_out  (clk_out),
    .rst_n    (rst_n),
    .clr_term (clr_term),
    .cfg_mode (cfg_mode),
    .d_pol    (d_pol),
    .e_pol    (e_pol),
    .cell_val (cell_val)
  );

  sumterm_pinstage #(.BURIED(BURIED)) u_pin (
    .cell_val  (cell_val),
    .oe_term   (oe_term),
    .pin_ext   (pin_ext),
    .pin_drive (pin_drive),
    .pin_en    (pin_en),
    .fb_true   (fb_true),
    .fb_comp   (fb_comp),
    .fb_pin    (fb_pin)
  );
endmodule

// File: rtl/sumterm_macrocell_chk.sv
module sumterm_macrocell_chk #(
  parameter bit BURIED = 1'b0
) (
  input logic       clk_out,
  input logic       rst_n,
  input logic       clr_term,
  input logic [1:0] cfg_mode,
  input logic       cfg_d_inv,
  input logic       cfg_e_inv,
  input logic       d_term,
  input logic       e_term,
  input logic       oe_term,
  input logic       pin_ext,
  input logic       pin_drive,
  input logic       pin_en,
  input logic       fb_true,
  input logic       fb_comp,
  input logic       fb_pin
);
  logic e_act;
  assign e_act = e_term ^ cfg_e_inv;

  AST_COMP_FEEDBACK: assert property (@(posedge clk_out) disable iff (!rst_n)
    fb_comp == ~fb_true); // R6

  AST_DE_LOAD: assert property (@(posedge clk_out) disable iff (!rst_n || clr_term)
    (cfg_mode == 2'b10 && e_act) |=>
      (cfg_mode != 2'b10 || fb_true == $past(d_term ^ cfg_d_inv))); // R2

  AST_DE_HOLD: assert property (@(posedge clk_out) disable iff (!rst_n || clr_term)
    (cfg_mode == 2'b10 && !e_act) |=> (cfg_mode != 2'b10 || $stable(fb_true))); // R9

  AST_CLR_ZERO: assert property (@(posedge clk_out) disable iff (!rst_n)
    (clr_term && (cfg_mode == 2'b01 || cfg_mode == 2'b10)) |-> !fb_true); // R4

  generate
    if (BURIED) begin : g_bur
      AST_BURIED_QUIET: assert property (@(posedge clk_out) disable iff (!rst_n)
        !pin_en && !pin_drive && fb_pin == pin_ext); // R8
    end else begin : g_io
      AST_PIN_INVERT: assert property (@(posedge clk_out) disable iff (!rst_n)
        pin_drive == ~fb_true); // R5
      AST_PIN_FEEDBACK: assert property (@(posedge clk_out) disable iff (!rst_n)
        fb_pin == (pin_en ? pin_drive : pin_ext)); // R7
    end
  endgenerate
endmodule

bind sumterm_macrocell sumterm_macrocell_chk #(.BURIED(BURIED)) u_chk (
  .clk_out   (clk_out),
  .rst_n     (rst_n),
  .clr_term  (clr_term),
  .cfg_mode  (cfg_mode),
  .cfg_d_inv (cfg_d_inv),
  .cfg_e_inv (cfg_e_inv),
  .d_term    (d_term),
  .e_term    (e_term),
  .oe_term   (oe_term),
  .pin_ext   (pin_ext),
  .pin_drive (pin_drive),
  .pin_en    (pin_en),
  .fb_true   (fb_true),
  .fb_comp   (fb_comp),
  .fb_pin    (fb_pin)
);

// File: tb/tb_sumterm_macrocell.sv
`timescale 1ns/1ps
module tb_sumterm_macrocell;
  logic       clk_out = 1'b0;
  logic       rst_n, clr_term, cfg_d_inv, cfg_e_inv;
  logic [1:0] cfg_mode;
  logic       d_term, e_term, oe_term, pin_ext;
  logic       pin_drive, pin_en, fb_true, fb_comp, fb_pin;
  logic       b_drive, b_en, b_true, b_comp, b_pin;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk_out = ~clk_out;

  sumterm_macrocell #(.BURIED(1'b0)) dut (
    .clk_out(clk_out), .rst_n(rst_n), .clr_term(clr_term), .cfg_mode(cfg_mode),
    .cfg_d_inv(cfg_d_inv), .cfg_e_inv(cfg_e_inv), .d_term(d_term), .e_term(e_term),
    .oe_term(oe_term), .pin_ext(pin_ext), .pin_drive(pin_drive), .pin_en(pin_en),
    .fb_true(fb_true), .fb_comp(fb_comp), .fb_pin(fb_pin));

  sumterm_macrocell #(.BURIED(1'b1)) dut_b (
    .clk_out(clk_out), .rst_n(rst_n), .clr_term(clr_term), .cfg_mode(cfg_mode),
    .cfg_d_inv(cfg_d_inv), .cfg_e_inv(cfg_e_inv), .d_term(d_term), .e_term(e_term),
    .oe_term(oe_term), .pin_ext(pin_ext), .pin_drive(b_drive), .pin_en(b_en),
    .fb_true(b_true), .fb_comp(b_comp), .fb_pin(b_pin));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic after_rise();
    @(posedge clk_out);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clr_term = 1'b0; cfg_mode = 2'b10; cfg_d_inv = 1'b0; cfg_e_inv = 1'b0;
    d_term = 1'b1; e_term = 1'b1; oe_term = 1'b1; pin_ext = 1'b0;
    repeat (3) after_rise();
    check("R4 reset fb_true", fb_true, 1'b0);
    check("R4 reset pin_drive", pin_drive, 1'b1);
    check("R6 reset fb_comp", fb_comp, 1'b1);
    @(negedge clk_out);
    rst_n = 1'b1; e_term = 1'b0;
  endtask

  task automatic t_comb();
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 4; v++) begin
        @(negedge clk_out);
        cfg_mode = (m == 0) ? 2'b00 : 2'b11;
        d_term = v[0]; cfg_d_inv = v[1];
        #1;
        check("R1 comb fb_true", fb_true, v[0] ^ v[1]);
        check("R5 pin inverts", pin_drive, ~(v[0] ^ v[1]));
        check("R6 comp", fb_comp, ~(v[0] ^ v[1]));
        check("R8 buried fb_true", b_true, v[0] ^ v[1]);
      end
    end
    cfg_d_inv = 1'b0;
  endtask

  task automatic t_de();
    @(negedge clk_out);
    cfg_mode = 2'b10; cfg_e_inv = 1'b0; d_term = 1'b1; e_term = 1'b1;
    after_rise();
    check("R2 load 1", fb_true, 1'b1);
    @(negedge clk_out);
    d_term = 1'b0; e_term = 1'b0;
    after_rise();
    check("R2 hold", fb_true, 1'b1);
    @(negedge clk_out);
    e_term = 1'b1; #0.5; e_term = 1'b0; #0.5; e_term = 1'b1; #0.5;
    check("R9 enable edges ignored in clock-enable mode", fb_true, 1'b1);
    after_rise();
    check("R2 load 0", fb_true, 1'b0);
    @(negedge clk_out);
    cfg_e_inv = 1'b1; e_term = 1'b0; d_term = 1'b1;
    after_rise();
    check("R2 inverted enable loads", fb_true, 1'b1);
    @(negedge clk_out);
    e_term = 1'b1; d_term = 1'b0;
    after_rise();
    check("R2 inverted enable holds", fb_true, 1'b1);
    @(negedge clk_out);
    e_term = 1'b0; cfg_d_inv = 1'b1; d_term = 1'b1;
    after_rise();
    check("R2 data inversion", fb_true, 1'b0);
    @(negedge clk_out);
    cfg_d_inv = 1'b0; cfg_e_inv = 1'b0; e_term = 1'b1; d_term = 1'b1;
    after_rise();
    @(negedge clk_out);
    clr_term = 1'b1;
    #1;
    check("R4 clear async in clock-enable mode", fb_true, 1'b0);
    check("R4 cleared pin high", pin_drive, 1'b1);
    @(negedge clk_out);
    clr_term = 1'b0;
    #1;
    check("R4 clear persists until clock", fb_true, 1'b0);
    after_rise();
    check("R2 reload after clear", fb_true, 1'b1);
  endtask

  task automatic t_st();
    @(negedge clk_out);
    cfg_e_inv = 1'b0; e_term = 1'b0; d_term = 1'b0;
    @(negedge clk_out);
    cfg_mode = 2'b01; d_term = 1'b1;
    #0.5; e_term = 1'b1; #0.5;
    check("R3 rising enable loads 1", fb_true, 1'b1);
    @(negedge clk_out);
    d_term = 1'b0;
    repeat (2) after_rise();
    check("R9 clk_out ignored in sum-term clock mode", fb_true, 1'b1);
    @(negedge clk_out);
    e_term = 1'b0; #1;
    check("R3 falling enable no load", fb_true, 1'b1);
    e_term = 1'b1; #0.5;
    check("R3 rising enable loads 0", fb_true, 1'b0);
    @(negedge clk_out);
    cfg_e_inv = 1'b1; d_term = 1'b1;
    #0.5; e_term = 1'b0; #0.5;
    check("R3 inverted: falling e_term loads", fb_true, 1'b1);
    @(negedge clk_out);
    clr_term = 1'b1; #1;
    check("R4 clear async in sum-term clock mode", fb_true, 1'b0);
    check("R5 cleared pin high", pin_drive, 1'b1);
    check("R8 buried also cleared", b_true, 1'b0);
    @(negedge clk_out);
    clr_term = 1'b0; cfg_e_inv = 1'b0;
  endtask

  task automatic t_pin();
    @(negedge clk_out);
    cfg_mode = 2'b00; d_term = 1'b1; oe_term = 1'b1; pin_ext = 1'b1;
    #1;
    check("R7 pin_en follows oe", pin_en, 1'b1);
    check("R7 fb_pin from driver", fb_pin, 1'b0);
    check("R8 buried no drive enable", b_en, 1'b0);
    check("R8 buried pin_drive low", b_drive, 1'b0);
    check("R8 buried fb_pin is pad", b_pin, 1'b1);
    @(negedge clk_out);
    oe_term = 1'b0; pin_ext = 1'b1;
    #1;
    check("R7 hi-z pin_en", pin_en, 1'b0);
    check("R7 fb_pin from pad 1", fb_pin, 1'b1);
    pin_ext = 1'b0; #1;
    check("R7 fb_pin from pad 0", fb_pin, 1'b0);
    check("R8 buried fb_pin from pad 0", b_pin, 1'b0);
    check("R8 buried comp", b_comp, 1'b0);
  endtask

  initial begin
    t_reset();
    t_comb();
    t_de();
    t_st();
    t_pin();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule